// File: doc/BRIEF.md
# Keyboard and Character Display Bus Port

This block is a bus slave for a 16-bit processor. It gives software a polled keyboard input channel and a polled character output channel, each reached through a status word and a data word in a small window of the address map. A key source presents an 8-bit code with a one-cycle strobe. The block captures the code and raises a ready flag. It then refuses further keys until software reads the code. On the output side, software writes a character. The block emits it to a character sink as a one-cycle pulse and reports busy until the sink answers with a done strobe.

Bus reads are combinational by default, so read data is valid in the same cycle as the read strobe. Side effects of an access take place at the clock edge that ends it. A parameter can select a registered read path instead. A select output tells main memory to stay idle on any access that lands on one of the four registers. The window base, the register stride, the word and character widths and the position of the flag bit are all parameters.

Top module: `kbd_disp_port`

## Requirements
- R1: The registers sit at BASE+0 (key status), BASE+2 (key data), BASE+4 (display status) and BASE+6 (display data), with BASE = 0xFE00. `mem_inhibit` is 1 exactly when `bus_rd` or `bus_wr` is high and `bus_addr` equals one of these four addresses.
- R2: After a key strobe is captured, a read of key status returns 0x8000, meaning bit 15 is set and every other bit is 0.
- R3: A read of key data returns the captured code in bits [7:0], with bits [15:8] equal to 0.
- R4: While the key flag is set, further key strobes are discarded, and key data keeps the first code.
- R5: A read of key data clears the key flag at the end of that access, so key status then reads 0, and the next key strobe is captured again.
- R6: After reset, display status reads 0x8000, key status reads 0, key data reads 0, and `disp_valid` and `mem_inhibit` are 0.
- R7: A write to display data while display status bit 15 is 1 produces `disp_valid` = 1 for exactly the one cycle after the write edge, with `disp_char` equal to the written bits [7:0]. Display status then reads 0.
- R8: A write to display data while display status bit 15 is 0 is ignored. It produces no `disp_valid` pulse, and the next accepted write still shows its own character.
- R9: A `disp_done` strobe while the display is busy sets display status back to 0x8000.
- R10: Reads of display data, and reads of any address outside the four registers, return 0. Writes to the other three registers change nothing that can be observed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Word address of the access |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 16 | Read data |
| mem_inhibit | output | 1 | High when the access is served by this block |
| key_valid | input | 1 | One-cycle strobe that a key code is present |
| key_code | input | 8 | Key character code |
| disp_valid | output | 1 | One-cycle strobe that a character is sent |
| disp_char | output | 8 | Character sent to the sink |
| disp_done | input | 1 | Sink finished, ready for another character |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that each strobe stands for one access that completes at the next edge, and that `disp_done` comes only from a sink that has been handed a character. The bench follows these rules. It drives every bus access as a single-cycle strobe set up at the falling edge. It raises `disp_done` only after an accepted write. It sweeps all 256 codes through both channels, and each key strobe that must be dropped arrives between a capture and the read of key data.

// File: rtl/kdm_pkg.sv
`timescale 1ns/1ps
package kdm_pkg;
   typedef enum logic [1:0] {
      SEL_KSTAT = 2'd0,
      SEL_KDATA = 2'd1,
      SEL_DSTAT = 2'd2,
      SEL_DDATA = 2'd3
   } kdm_sel_e;

   localparam int unsigned NUM_REGS = 4;

   function automatic logic [1:0] onehot_to_idx(input logic [NUM_REGS-1:0] oh);
      logic [1:0] idx;
      idx = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (oh[k]) idx = 2'(k);
      end
      return idx;
   endfunction
endpackage

// File: rtl/kdm_decode.sv
`timescale 1ns/1ps
module kdm_decode
   import kdm_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BASE   = 'hFE00,
   parameter int unsigned STRIDE = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output logic              any_hit,
   output kdm_sel_e          sel,
   output logic              rd_kdata,
   output logic              wr_ddata
);
   localparam int unsigned SPAN = NUM_REGS * STRIDE;

   if (STRIDE == 0) begin : g_bad_stride
      $error("kdm_decode: STRIDE must be nonzero");
   end
   if (BASE + SPAN > (64'd1 << ADDR_W)) begin : g_bad_base
      $error("kdm_decode: register window exceeds address space");
   end

   logic [NUM_REGS-1:0] hit;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(BASE + i * STRIDE);
      assign hit[i] = (addr == REG_ADDR);
   end

   logic access;
   assign access   = rd | wr;
   assign any_hit  = access & (|hit);
   assign sel      = kdm_sel_e'(onehot_to_idx(hit));
   assign rd_kdata = rd & hit[SEL_KDATA];
   assign wr_ddata = wr & hit[SEL_DDATA];
endmodule

// File: rtl/kdm_kbd.sv
`timescale 1ns/1ps
module kdm_kbd #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_valid,
   input  logic [CHAR_W-1:0] key_code,
   input  logic              rd_kdata,
   output logic              ready,
   output logic [CHAR_W-1:0] char_q
);
   logic capture;
   assign capture = key_valid & ~ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready  <= 1'b0;
         char_q <= '0;
      end else if (capture) begin
         ready  <= 1'b1;
         char_q <= key_code;
      end else if (rd_kdata) begin
         ready  <= 1'b0;
      end
   end
endmodule

// File: rtl/kdm_disp.sv
`timescale 1ns/1ps
module kdm_disp #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ddata,
   input  logic [CHAR_W-1:0] wchar,
   input  logic              done,
   output logic              ready,
   output logic              valid,
   output logic [CHAR_W-1:0] char_q
);
   logic accept;
   assign accept = wr_ddata & ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready  <= 1'b1;
         valid  <= 1'b0;
         char_q <= '0;
      end else begin
         valid <= accept;
         if (accept) begin
            ready  <= 1'b0;
            char_q <= wchar;
         end else if (!ready && done) begin
            ready <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/kdm_rdmux.sv
`timescale 1ns/1ps
module kdm_rdmux
   import kdm_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CHAR_W    = 8,
   parameter int unsigned FLAG_BIT  = 15,
   parameter bit          READ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              any_hit,
   input  kdm_sel_e          sel,
   input  logic              kb_ready,
   input  logic [CHAR_W-1:0] kb_char,
   input  logic              dp_ready,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mux;

   always_comb begin
      mux = '0;
      if (rd && any_hit) begin
         unique case (sel)
            SEL_KSTAT: mux[FLAG_BIT] = kb_ready;
            SEL_KDATA: mux[CHAR_W-1:0] = kb_char;
            SEL_DSTAT: mux[FLAG_BIT] = dp_ready;
            SEL_DDATA: mux = '0;
            default:   mux = '0;
         endcase
      end
   end

   if (READ_REG) begin : g_reg_read
      always_ff @(posedge clk) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= mux;
      end
   end else begin : g_comb_read
      logic unused_rd_clk;
      assign unused_rd_clk = clk ^ rst_n;
      assign rdata = mux;
   end
endmodule

// File: rtl/kbd_disp_port.sv
`timescale 1ns/1ps
module kbd_disp_port
   import kdm_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned CHAR_W   = 8,
   parameter int unsigned BASE     = 'hFE00,
   parameter int unsigned STRIDE   = 2,
   parameter int unsigned FLAG_BIT = 15,
   parameter bit          READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              mem_inhibit,
   input  logic              key_valid,
   input  logic [CHAR_W-1:0] key_code,
   output logic              disp_valid,
   output logic [CHAR_W-1:0] disp_char,
   input  logic              disp_done
);
   if (CHAR_W > DATA_W) begin : g_bad_char
      $error("kbd_disp_port: CHAR_W exceeds DATA_W");
   end
   if (FLAG_BIT >= DATA_W) begin : g_bad_flag
      $error("kbd_disp_port: FLAG_BIT outside data word");
   end

   logic     any_hit, rd_kdata, wr_ddata;
   kdm_sel_e sel;
   logic     kb_rdy, dp_rdy;
   logic [CHAR_W-1:0] kb_char;

   logic unused_wdata_hi;
   if (DATA_W > CHAR_W) begin : g_wdata_hi
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CHAR_W];
   end else begin : g_wdata_full
      assign unused_wdata_hi = 1'b0;
   end

   kdm_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)) u_decode (
      .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
      .any_hit(any_hit), .sel(sel), .rd_kdata(rd_kdata), .wr_ddata(wr_ddata)
   );

   kdm_kbd #(.CHAR_W(CHAR_W)) u_kbd (
      .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
      .rd_kdata(rd_kdata), .ready(kb_rdy), .char_q(kb_char)
   );

   kdm_disp #(.CHAR_W(CHAR_W)) u_disp (
      .clk(clk), .rst_n(rst_n), .wr_ddata(wr_ddata),
      .wchar(bus_wdata[CHAR_W-1:0]), .done(disp_done),
      .ready(dp_rdy), .valid(disp_valid), .char_q(disp_char)
   );

   kdm_rdmux #(.DATA_W(DATA_W), .CHAR_W(CHAR_W), .FLAG_BIT(FLAG_BIT),
               .READ_REG(READ_REG)) u_rdmux (
      .clk(clk), .rst_n(rst_n), .rd(bus_rd), .any_hit(any_hit), .sel(sel),
      .kb_ready(kb_rdy), .kb_char(kb_char), .dp_ready(dp_rdy), .rdata(bus_rdata)
   );

   assign mem_inhibit = any_hit;
endmodule

// File: rtl/kbd_disp_port_chk.sv
`timescale 1ns/1ps
module kbd_disp_port_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CHAR_W = 8,
   parameter int unsigned BASE   = 'hFE00,
   parameter int unsigned STRIDE = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              mem_inhibit,
   input logic              key_valid,
   input logic              disp_valid,
   input logic [CHAR_W-1:0] disp_char,
   input logic              disp_done,
   input logic              kb_rdy,
   input logic [CHAR_W-1:0] kb_char,
   input logic              dp_rdy
);
   logic [ADDR_W-1:0] off;
   logic at_kdata, at_ddata;
   assign off      = bus_addr - ADDR_W'(BASE);
   assign at_kdata = (bus_addr == ADDR_W'(BASE + STRIDE));
   assign at_ddata = (bus_addr == ADDR_W'(BASE + 3 * STRIDE));

   AST_SEL_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_inhibit |-> (bus_rd || bus_wr)); // R1
   AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      mem_inhibit |-> (off < ADDR_W'(4 * STRIDE))); // R1
   AST_KEY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (!kb_rdy && key_valid) |=> kb_rdy); // R2
   AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (kb_rdy && !(bus_rd && at_kdata)) |=> (kb_rdy && $stable(kb_char))); // R4
   AST_KEY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (kb_rdy && bus_rd && at_kdata) |=> !kb_rdy); // R5
   AST_DISP_SEND: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_rdy && bus_wr && at_ddata) |=>
      (disp_valid && !dp_rdy && disp_char == $past(bus_wdata[CHAR_W-1:0]))); // R7
   AST_DISP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |=> !disp_valid); // R7
   AST_DISP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!dp_rdy && bus_wr && at_ddata) |=> !disp_valid); // R8
   AST_DISP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!dp_rdy && disp_done) |=> dp_rdy); // R9
endmodule

bind kbd_disp_port kbd_disp_port_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .BASE(BASE), .STRIDE(STRIDE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rd(bus_rd), .bus_wr(bus_wr), .mem_inhibit(mem_inhibit),
   .key_valid(key_valid), .disp_valid(disp_valid), .disp_char(disp_char),
   .disp_done(disp_done), .kb_rdy(kb_rdy), .kb_char(kb_char), .dp_rdy(dp_rdy)
);

// File: tb/kbd_disp_port_bench.sv
`timescale 1ns/1ps
module kbd_disp_port_bench;
   localparam logic [15:0] A_KS = 16'hFE00;
   localparam logic [15:0] A_KD = 16'hFE02;
   localparam logic [15:0] A_DS = 16'hFE04;
   localparam logic [15:0] A_DD = 16'hFE06;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_rdata;
   logic        mem_inhibit;
   logic        key_valid = 1'b0;
   logic [7:0]  key_code = '0;
   logic        disp_valid;
   logic [7:0]  disp_char;
   logic        disp_done = 1'b0;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   kbd_disp_port u_kbd_disp_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
      .mem_inhibit(mem_inhibit), .key_valid(key_valid), .key_code(key_code),
      .disp_valid(disp_valid), .disp_char(disp_char), .disp_done(disp_done)
   );

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [15:0] d,
                           output logic sel);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata; sel = mem_inhibit;
      @(posedge clk); #1 bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [15:0] d,
                            output logic pulse, output logic [7:0] ch);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1 bus_wr = 1'b0;
      pulse = disp_valid; ch = disp_char;
   endtask

   task automatic press(input logic [7:0] c);
      @(negedge clk);
      key_valid = 1'b1; key_code = c;
      @(posedge clk); #1 key_valid = 1'b0;
   endtask

   task automatic sink_done();
      @(negedge clk);
      disp_done = 1'b1;
      @(posedge clk); #1 disp_done = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic s, p;
      logic [7:0] ch;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R6 reset state
      check(disp_valid == 1'b0, "R6 disp_valid", {15'd0, disp_valid}, 16'd0);
      check(mem_inhibit == 1'b0, "R6 mem_inhibit idle", {15'd0, mem_inhibit}, 16'd0);
      bus_read(A_KS, d, s); check(d == 16'h0000, "R6 key status", d, 16'h0000);
      bus_read(A_KD, d, s); check(d == 16'h0000, "R6 key data", d, 16'h0000);
      bus_read(A_DS, d, s); check(d == 16'h8000, "R6 display status", d, 16'h8000);

      // R1, R10 address sweep around the window
      for (int a = 'hFDF0; a < 'hFE10; a++) begin
         logic mapped;
         mapped = (a == 'hFE00) || (a == 'hFE02) || (a == 'hFE04) || (a == 'hFE06);
         bus_read(16'(a), d, s);
         check(s == mapped, "R1 select on read", {15'd0, s}, {15'd0, mapped});
         if (!mapped || a == 'hFE06)
            check(d == 16'h0000, "R10 unmapped or display data read", d, 16'h0000);
      end
      @(negedge clk); bus_addr = A_KS; #1
      check(mem_inhibit == 1'b0, "R1 no strobe no select", {15'd0, mem_inhibit}, 16'd0);

      // R10 writes to other registers have no effect
      bus_write(A_KS, 16'hFFFF, p, ch);
      bus_write(A_KD, 16'h00AA, p, ch);
      bus_write(A_DS, 16'h0000, p, ch);
      check(p == 1'b0, "R10 no pulse", {15'd0, p}, 16'd0);
      bus_read(A_KS, d, s); check(d == 16'h0000, "R10 key status kept", d, 16'h0000);
      bus_read(A_KD, d, s); check(d == 16'h0000, "R10 key data kept", d, 16'h0000);
      bus_read(A_DS, d, s); check(d == 16'h8000, "R10 display status kept", d, 16'h8000);

      // Keyboard sweep: R2 R3 R4 R5
      for (int c = 0; c < 256; c++) begin
         logic [7:0] cc, junk;
         cc = 8'(c);
         junk = cc ^ 8'h5A;
         press(cc);
         bus_read(A_KS, d, s); check(d == 16'h8000, "R2 key flag set", d, 16'h8000);
         press(junk);
         bus_read(A_KS, d, s); check(d == 16'h8000, "R4 flag held", d, 16'h8000);
         bus_read(A_KD, d, s);
         check(d == {8'h00, cc}, "R3 R4 key data", d, {8'h00, cc});
         bus_read(A_KS, d, s); check(d == 16'h0000, "R5 flag cleared", d, 16'h0000);
      end

      // Display sweep: R7 R8 R9
      for (int c = 0; c < 256; c++) begin
         logic [7:0] cc;
         cc = 8'(c);
         bus_write(A_DD, {8'hC3, cc}, p, ch);
         check(p == 1'b1, "R7 pulse", {15'd0, p}, 16'd1);
         check(ch == cc, "R7 char", {8'd0, ch}, {8'd0, cc});
         @(posedge clk); #1
         check(disp_valid == 1'b0, "R7 single pulse", {15'd0, disp_valid}, 16'd0);
         bus_read(A_DS, d, s); check(d == 16'h0000, "R7 busy", d, 16'h0000);
         bus_write(A_DD, {8'h00, ~cc}, p, ch);
         check(p == 1'b0, "R8 dropped write", {15'd0, p}, 16'd0);
         sink_done();
         bus_read(A_DS, d, s); check(d == 16'h8000, "R9 ready again", d, 16'h8000);
      end

      // R8 next accepted write shows its own character
      bus_write(A_DD, 16'h0041, p, ch);
      bus_write(A_DD, 16'h0042, p, ch);
      sink_done();
      bus_write(A_DD, 16'h0043, p, ch);
      check(p == 1'b1 && ch == 8'h43, "R8 later write", {7'd0, p, ch}, 16'h0143);
      sink_done();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule